// File: doc/BRIEF.md
# Register-Read Host Port for a Data-Line Decoder

This block is the two-wire serial slave of a data-line decoder. It runs on the system clock. SCL and SDA are oversampled through two-flop synchronizers. START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high. A chip-select pin chooses one of two address pairs. After a write address the block accepts one control byte. After a read address it streams the transfer bank MSB first, and the byte pointer steps forward on every master acknowledge. The acquisition logic offers freshly decoded bytes with a store strobe. That strobe is dropped while the host owns the port. A read that ends presets the bank to FFh.

The protocol machine has these states. `ST_IDLE` waits for START. `ST_ADDR` shifts in the address byte. `ST_ADDR_ACK` drives the address acknowledge. `ST_WR_DATA` receives the control byte. `ST_WR_ACK` acknowledges it. `ST_RD_DATA` shifts a byte out. `ST_RD_ACK` samples the master acknowledge. `ST_SKIP` waits for the bus to end the transfer.

Transitions:
- A STOP from any state goes to `ST_IDLE`.
- A START from any state goes to `ST_ADDR`.
- The eighth address bit leads to `ST_ADDR_ACK` on a match, or back to `ST_IDLE` on a mismatch.
- The acknowledge clock leads to `ST_RD_DATA` or `ST_WR_DATA`, depending on the R/W bit.
- A full control byte leads to `ST_WR_ACK`, and from there to `ST_SKIP`.
- The eighth data bit leads to `ST_RD_ACK`.
- A master ACK returns to `ST_RD_DATA`. A master NACK goes to `ST_SKIP`.

Top module: `dl_host_i2c_slave`

## Requirements
- R1: The 8-bit address byte is matched against 20h (write) and 21h (read) when `cs_sel` is 0, and against 22h and 23h when `cs_sel` is 1. A matching address is acknowledged. Any other address gets no acknowledge, and the slave stays off the bus until the next START.
- R2: `ctrl_out` resets to 00h. A write transfer loads the single data byte into it and acknowledges that byte. Bit 1 is the mode select (0 = line mode, 1 = packet mode). Bit 0 is the packet-format select.
- R3: A read returns the bank bytes MSB first. The first byte sent is `acq_bytes[7:0]` and byte k is `acq_bytes[8k-1:8k-8]`. Each master ACK moves on to the next byte.
- R4: Every START resets the byte pointer, so each read begins with the first byte.
- R5: Any byte requested after the seventh reads as FFh.
- R6: On a master NACK the slave releases SDA, sends nothing more until the next START, and forces `dav_n` high.
- R7: When a read transfer ends (STOP or repeated START), all seven bank bytes become FFh until the next accepted store.
- R8: `host_busy` is high from START until STOP or an address mismatch. A store strobe that arrives while `host_busy` is high is dropped.
- R9: `dav_n` resets high. It goes low on an accepted store with `acq_flag` = 1. It returns high on `dav_release`. A store with `acq_flag` = 0 leaves it unchanged.
- R10: With `test_en` = 1, `dav_n` and `field_out` both equal `cs_sel`. Otherwise `field_out` follows `field_in`.
- R11: The slave only ever pulls SDA low, through `sda_oe`. It asserts the drive only while SCL is low, and the drive is off whenever no transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cs_sel | input | 1 | Address-pair select pin |
| test_en | input | 1 | Test override of the status outputs |
| acq_store | input | 1 | Acquisition store strobe |
| acq_flag | input | 1 | Store is signalled on `dav_n` |
| acq_bytes | input | 56 | Seven decoded bytes, first byte in [7:0] |
| dav_release | input | 1 | Return `dav_n` high (start of data window) |
| field_in | input | 1 | First-field indication from timing |
| dav_n | output | 1 | Data available, active low |
| field_out | output | 1 | First-field output |
| host_busy | output | 1 | Host access in progress |
| ctrl_out | output | 8 | Control register |

## Verification
Bus events reach the machine three system clocks after the wire changes: two synchronizer flops and one edge register. As a result, SDA is driven three clocks after a falling SCL. The bench holds each SCL phase for ten clocks and samples SDA halfway through the high phase, well after the drive has settled. A store or a `dav_release` shows on `dav_n` one clock after the strobe edge, and a read end presets the bank one clock after STOP is detected. The bench therefore waits at least two clocks before checking either. The test-mode mux is combinational and is checked one clock after `test_en` or `cs_sel` changes.

// File: rtl/dl_host_pkg.sv
package dl_host_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_SKIP
    } host_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/dl_line_sync.sv
module dl_line_sync
    import dl_host_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/dl_xfer_bank.sv
module dl_xfer_bank
    import dl_host_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 7,
    parameter int unsigned IDX_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        store_en,
    input  logic [NUM_BYTES*BYTE_W-1:0] store_data,
    input  logic                        preset,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [BYTE_W-1:0]           rd_byte
);
    logic [BYTE_W-1:0] regs_q [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '1;
            end else if (preset) begin
                regs_q[g] <= '1;
            end else if (store_en) begin
                regs_q[g] <= store_data[g*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        rd_byte = '1;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_idx == IDX_W'(i)) rd_byte = regs_q[i];
        end
    end

endmodule

// File: rtl/dl_proto_fsm.sv
module dl_proto_fsm
    import dl_host_pkg::*;
#(
    parameter logic [6:0]  ADDR_BASE = 7'h10,
    parameter int unsigned NUM_BYTES = 7,
    parameter int unsigned IDX_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              cs_sel,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              busy,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              nack_evt,
    output logic              read_end
);
    host_state_e       state_q, state_d;
    logic [2:0]        bitcnt;
    logic              byte_full;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              is_read;
    logic              ack_q;
    logic              read_phase;
    logic [6:0]        my_addr;
    logic              addr_hit;

    assign my_addr  = ADDR_BASE + {6'd0, cs_sel};
    assign addr_hit = (shreg[7:1] == my_addr);
    assign busy     = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        if (evt.stop) begin
            state_d = ST_IDLE;
        end else if (evt.start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (evt.scl_fall && byte_full)
                                 state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (evt.scl_fall)
                                 state_d = is_read ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (evt.scl_fall && byte_full) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (evt.scl_fall) state_d = ST_SKIP;
                ST_RD_DATA:  if (evt.scl_fall && bitcnt == 3'd7) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (evt.scl_fall) state_d = ack_q ? ST_RD_DATA : ST_SKIP;
                ST_SKIP:     state_d = ST_SKIP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            byte_full  <= 1'b0;
            shreg      <= '0;
            txreg      <= '1;
            is_read    <= 1'b0;
            ack_q      <= 1'b0;
            read_phase <= 1'b0;
            sda_oe     <= 1'b0;
            ctrl_q     <= '0;
            rd_idx     <= '0;
            nack_evt   <= 1'b0;
            read_end   <= 1'b0;
        end else begin
            nack_evt <= 1'b0;
            read_end <= 1'b0;
            if (evt.stop) begin
                sda_oe     <= 1'b0;
                read_end   <= read_phase;
                read_phase <= 1'b0;
            end else if (evt.start) begin
                sda_oe     <= 1'b0;
                bitcnt     <= '0;
                byte_full  <= 1'b0;
                rd_idx     <= '0;
                read_end   <= read_phase;
                read_phase <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_DATA: begin
                        if (evt.scl_rise && !byte_full) begin
                            shreg  <= {shreg[6:0], evt.sda};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) byte_full <= 1'b1;
                        end
                        if (evt.scl_fall && byte_full) begin
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe  <= 1'b1;
                                    is_read <= shreg[0];
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                ctrl_q <= shreg;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            bitcnt    <= '0;
                            byte_full <= 1'b0;
                            if (is_read) begin
                                read_phase <= 1'b1;
                                txreg      <= {rd_byte[6:0], 1'b1};
                                sda_oe     <= ~rd_byte[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RD_DATA: begin
                        if (evt.scl_fall) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                            end else begin
                                sda_oe <= ~txreg[7];
                                txreg  <= {txreg[6:0], 1'b1};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            ack_q <= ~evt.sda;
                            if (!evt.sda && rd_idx != IDX_W'(NUM_BYTES))
                                rd_idx <= rd_idx + 1'b1;
                        end
                        if (evt.scl_fall) begin
                            if (ack_q) begin
                                bitcnt <= '0;
                                txreg  <= {rd_byte[6:0], 1'b1};
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                nack_evt <= 1'b1;
                            end
                        end
                    end
                    ST_IDLE, ST_SKIP: ;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dl_host_i2c_slave.sv
module dl_host_i2c_slave
    import dl_host_pkg::*;
#(
    parameter int unsigned N_BYTES   = 7,
    parameter logic [6:0]  ADDR_BASE = 7'h10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    output logic                      sda_oe,
    input  logic                      cs_sel,
    input  logic                      test_en,
    input  logic                      acq_store,
    input  logic                      acq_flag,
    input  logic [N_BYTES*BYTE_W-1:0] acq_bytes,
    input  logic                      dav_release,
    input  logic                      field_in,
    output logic                      dav_n,
    output logic                      field_out,
    output logic                      host_busy,
    output logic [BYTE_W-1:0]         ctrl_out
);
    localparam int unsigned IDX_W = $clog2(N_BYTES + 1);

    bus_evt_t          evt;
    logic [BYTE_W-1:0] rd_byte;
    logic [IDX_W-1:0]  rd_idx;
    logic              nack_evt;
    logic              read_end;
    logic              store_en;
    logic              dav_q;

    dl_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    dl_proto_fsm #(
        .ADDR_BASE (ADDR_BASE),
        .NUM_BYTES (N_BYTES),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .cs_sel   (cs_sel),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_oe),
        .busy     (host_busy),
        .ctrl_q   (ctrl_out),
        .rd_idx   (rd_idx),
        .nack_evt (nack_evt),
        .read_end (read_end)
    );

    assign store_en = acq_store & ~host_busy;

    dl_xfer_bank #(
        .NUM_BYTES (N_BYTES),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_en   (store_en),
        .store_data (acq_bytes),
        .preset     (read_end),
        .rd_idx     (rd_idx),
        .rd_byte    (rd_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        dav_q <= 1'b1;
        else if (nack_evt || dav_release)  dav_q <= 1'b1;
        else if (store_en && acq_flag)     dav_q <= 1'b0;
    end

    assign dav_n     = test_en ? cs_sel : dav_q;
    assign field_out = test_en ? cs_sel : field_in;

endmodule

// File: rtl/dl_host_i2c_chk.sv
module dl_host_i2c_chk #(
    parameter int unsigned CTRL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_in,
    input logic              sda_oe,
    input logic              host_busy,
    input logic              test_en,
    input logic              dav_n,
    input logic              acq_store,
    input logic [CTRL_W-1:0] ctrl_out,
    input logic              nack_evt
);
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> !sda_oe); // R11

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in); // R11

    AST_CTRL_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |=> $stable(ctrl_out)); // R2

    AST_STORE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && $past(!test_en) && $fell(dav_n))
        |-> ($past(acq_store) && !$past(host_busy))); // R8

    AST_NACK_DAV_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_evt && !test_en) |=> (dav_n || test_en)); // R6

endmodule

bind dl_host_i2c_slave dl_host_i2c_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .host_busy (host_busy),
    .test_en   (test_en),
    .dav_n     (dav_n),
    .acq_store (acq_store),
    .ctrl_out  (ctrl_out),
    .nack_evt  (nack_evt)
);

// File: tb/dl_host_i2c_slave_test.sv
`timescale 1ns/1ps
module dl_host_i2c_slave_test;
    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_w;
    logic        sda_oe;
    logic        cs_sel = 1'b0;
    logic        test_en = 1'b0;
    logic        acq_store = 1'b0;
    logic        acq_flag = 1'b0;
    logic [55:0] acq_bytes = '0;
    logic        dav_release = 1'b0;
    logic        field_in = 1'b0;
    logic        dav_n, field_out, host_busy;
    logic [7:0]  ctrl_out;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    assign sda_w = sda_m & ~sda_oe;

    dl_host_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_w), .sda_oe(sda_oe),
        .cs_sel(cs_sel), .test_en(test_en), .acq_store(acq_store), .acq_flag(acq_flag),
        .acq_bytes(acq_bytes), .dav_release(dav_release), .field_in(field_in),
        .dav_n(dav_n), .field_out(field_out), .host_busy(host_busy), .ctrl_out(ctrl_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    task automatic w(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic i_start();
        sda_m = 1'b1; scl_m = 1'b1; w(H);
        sda_m = 1'b0; w(H);
        scl_m = 1'b0; w(H);
    endtask

    task automatic i_stop();
        sda_m = 1'b0; w(H);
        scl_m = 1'b1; w(H);
        sda_m = 1'b1; w(H);
    endtask

    task automatic i_bit(input logic b, output logic r);
        sda_m = b; w(H);
        scl_m = 1'b1; w(H/2);
        r = sda_w; w(H/2);
        scl_m = 1'b0; w(H);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) i_bit(v[i], r);
        i_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            i_bit(1'b1, r);
            v[i] = r;
        end
        i_bit(~m_ack, r);
    endtask

    task automatic store(input logic [55:0] d, input logic flag);
        acq_bytes = d; acq_flag = flag; acq_store = 1'b1; w(1);
        acq_store = 1'b0; w(2);
    endtask

    function automatic logic [55:0] pattern(input logic [7:0] base);
        logic [55:0] p;
        for (int i = 0; i < 7; i++) p[i*8 +: 8] = base + 8'(i * 17);
        return p;
    endfunction

    // cs, address byte, expected acknowledge
    localparam logic [9:0] VEC [0:7] = '{
        {1'b0, 8'h20, 1'b1}, {1'b0, 8'h21, 1'b1}, {1'b0, 8'h22, 1'b0},
        {1'b0, 8'h23, 1'b0}, {1'b1, 8'h22, 1'b1}, {1'b1, 8'h23, 1'b1},
        {1'b1, 8'h20, 1'b0}, {1'b1, 8'h7E, 1'b0}
    };

    initial begin
        logic ack;
        logic [7:0] b;
        logic [55:0] p;

        w(5); rst_n = 1'b1; w(5);
        // reset state
        chk("R9 reset dav_n", dav_n, 1);
        chk("R2 reset ctrl", ctrl_out, 8'h00);
        chk("R8 reset busy", host_busy, 0);
        chk("R11 reset sda_oe", sda_oe, 0);
        chk("R10 field pass", field_out, 0);

        // R1 address table
        for (int k = 0; k < 8; k++) begin
            cs_sel = VEC[k][9];
            i_start();
            send_byte(VEC[k][8:1], ack);
            chk("R1 address ack", ack, VEC[k][0]);
            if (ack && VEC[k][1]) recv_byte(1'b0, b);
            if (!VEC[k][0]) chk("R1 mismatch busy", host_busy, 0);
            i_stop();
            w(4);
            chk("R11 released", sda_oe, 0);
        end

        // R2 control write
        cs_sel = 1'b0;
        i_start(); send_byte(8'h20, ack); send_byte(8'h03, ack);
        chk("R2 data ack", ack, 1); i_stop(); w(4);
        chk("R2 ctrl 03", ctrl_out, 8'h03);
        cs_sel = 1'b1;
        i_start(); send_byte(8'h22, ack); send_byte(8'h01, ack); i_stop(); w(4);
        chk("R2 ctrl 01", ctrl_out, 8'h01);

        // R9 store signalled
        p = pattern(8'h11);
        store(p, 1'b1);
        chk("R9 dav low", dav_n, 0);

        // R3 R5 R6 full read
        i_start(); send_byte(8'h23, ack);
        chk("R3 read ack", ack, 1);
        for (int k = 0; k < 8; k++) begin
            recv_byte(k < 7, b);
            if (k < 7) chk("R3 byte", b, p[k*8 +: 8]);
            else       chk("R5 beyond", b, 8'hFF);
        end
        w(3);
        chk("R6 nack dav", dav_n, 1);
        chk("R6 released", sda_oe, 0);
        i_stop(); w(4);

        // R7 preset after read
        i_start(); send_byte(8'h23, ack); recv_byte(1'b0, b); i_stop(); w(4);
        chk("R7 preset FF", b, 8'hFF);

        // R4 pointer reset at START, early end
        p = pattern(8'h40);
        store(p, 1'b0);
        chk("R9 flag0 dav", dav_n, 1);
        i_start(); send_byte(8'h23, ack);
        recv_byte(1'b1, b); chk("R4 first", b, p[7:0]);
        recv_byte(1'b0, b); chk("R3 second", b, p[15:8]);
        i_stop(); w(4);
        store(p, 1'b0);
        i_start(); send_byte(8'h23, ack);
        recv_byte(1'b0, b); chk("R4 restart", b, p[7:0]);
        i_stop(); w(4);

        // R8 store inhibited while busy
        i_start(); send_byte(8'h22, ack);
        chk("R8 busy", host_busy, 1);
        store(pattern(8'h90), 1'b1);
        chk("R8 dav unchanged", dav_n, 1);
        send_byte(8'h01, ack); i_stop(); w(4);
        i_start(); send_byte(8'h23, ack); recv_byte(1'b0, b); i_stop(); w(4);
        chk("R8 dropped", b, 8'hFF);

        // R9 release
        store(pattern(8'h05), 1'b1);
        chk("R9 dav low2", dav_n, 0);
        dav_release = 1'b1; w(1); dav_release = 1'b0; w(2);
        chk("R9 release", dav_n, 1);

        // R10 test mode
        test_en = 1'b1; cs_sel = 1'b0; w(1);
        chk("R10 dav cs0", dav_n, 0); chk("R10 field cs0", field_out, 0);
        cs_sel = 1'b1; w(1);
        chk("R10 dav cs1", dav_n, 1); chk("R10 field cs1", field_out, 1);
        test_en = 1'b0; field_in = 1'b1; cs_sel = 1'b0; w(1);
        chk("R10 field pass 1", field_out, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule